// File: doc/BRIEF.md
# Shared Add/Subtract Lane for Layered Min-Sum LLR Updates

This block is one lane of a layered min-sum decoder datapath. A single saturating ripple adder is shared between two jobs, and a mode bit picks the job for each clock cycle. In the first cycle of a layer step (mode 0) the lane subtracts the old check message from the old a-posteriori value. The result is the variable-to-check message. It is registered at full width and also handed to the check-node side after a second saturation to the narrow message width. In the second cycle (mode 1) the lane adds the fresh check message to the held variable-to-check message. The result is the new a-posteriori value, and it is registered.

Subtraction reuses the adder hardware. In mode 0 the mode bit sets the carry-in and inverts every bit of the second operand. In mode 1 the carry-in is clear and the second operand passes straight through. Operand multiplexers at the input and a write steer at the output follow the same bit. A lane-enable input serves check nodes of lower degree: when it is low, both check-message inputs are treated as zero, so the lane passes values through unchanged.

Top module: `llr_lane`

## Requirements
- R1: While `rstN` is low, `alphaWide`, `alphaNarrow` and `gammaNew` read zero.
- R2: At a rising edge with `modeSel`=0 and `laneOn`=1, `alphaWide` takes sat(gammaOld − betaOld). Both inputs are two's complement, and `betaOld` is sign-extended from NARROW_W to WIDE_W bits.
- R3: Every adder result saturates at WIDE_W bits. A positive overflow yields 2^(WIDE_W−1)−1 (+31 by default) and a negative overflow yields −2^(WIDE_W−1) (−32 by default).
- R4: `alphaNarrow` is registered on the same edge as `alphaWide`. It equals `alphaWide` clamped to the range −2^(NARROW_W−1) .. 2^(NARROW_W−1)−1, which is −8..+7 by default.
- R5: At a rising edge with `modeSel`=1 and `laneOn`=1, `gammaNew` takes sat(alphaWide + betaNew). The value of `alphaWide` used is the one held before that edge.
- R6: An edge with `modeSel`=1 leaves `alphaWide` and `alphaNarrow` unchanged. An edge with `modeSel`=0 leaves `gammaNew` unchanged.
- R7: With `laneOn`=0, both check-message inputs are taken as zero. In mode 0, `alphaWide` becomes `gammaOld`. In mode 1, `gammaNew` becomes the held `alphaWide`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 1 | 0 = variable-node subtract cycle, 1 = a-posteriori add cycle |
| laneOn | input | 1 | 0 forces both check-message inputs to zero |
| gammaOld | input | WIDE_W | Old a-posteriori LLR, two's complement |
| betaOld | input | NARROW_W | Old check-to-variable message, two's complement |
| betaNew | input | NARROW_W | New check-to-variable message, two's complement |
| alphaWide | output | WIDE_W | Held variable-to-check message |
| alphaNarrow | output | NARROW_W | Variable-to-check message narrowed for the check unit |
| gammaNew | output | WIDE_W | Updated a-posteriori LLR |

## Verification
The two alpha outputs come from a mode-0 cycle and are due right after the rising edge that closes that cycle. `gammaNew` comes from a mode-1 cycle and is due right after the edge that closes it. There is exactly one register stage in each case. The bench changes inputs on the falling edge and samples 1 ns after each rising edge. At that sample it compares the register the step was meant to write and also confirms that the other register kept its value. The expected mode-1 result is computed from the bench's own record of the alpha that the previous mode-0 step produced.

// File: rtl/llr_lane_pkg.sv
package llr_lane_pkg;

  // strobes from the lane control to the lane datapath
  typedef struct packed {
    logic captureAlpha;  // write the variable-to-check registers
    logic captureGamma;  // write the a-posteriori register
    logic carryIn;       // adder carry-in
    logic invertB;       // XOR-invert second operand
    logic pickStored;    // operand A from held alpha instead of gammaOld
    logic betaPass;      // 0 forces the check message to zero
  } laneStrobes_t;

endpackage

// File: rtl/llr_lane_ctrl.sv
module llr_lane_ctrl
  import llr_lane_pkg::*;
(
  input  logic         modeSel,
  input  logic         laneOn,
  output laneStrobes_t strobes
);

  always_comb begin
    strobes.captureAlpha = ~modeSel;
    strobes.captureGamma = modeSel;
    strobes.carryIn      = ~modeSel;
    strobes.invertB      = ~modeSel;
    strobes.pickStored   = modeSel;
    strobes.betaPass     = laneOn;
  end

endmodule

// File: rtl/llr_lane_adder.sv
module llr_lane_adder #(
  parameter int WIDE_W = 6
) (
  input  logic [WIDE_W-1:0] opA,
  input  logic [WIDE_W-1:0] opB,
  input  logic              invertB,
  input  logic              carryIn,
  output logic [WIDE_W-1:0] satSum
);

  localparam logic [WIDE_W-1:0] POS_LIMIT = {1'b0, {(WIDE_W-1){1'b1}}};
  localparam logic [WIDE_W-1:0] NEG_LIMIT = {1'b1, {(WIDE_W-1){1'b0}}};

  logic [WIDE_W:0]   carryChain;
  logic [WIDE_W-1:0] bMod;
  logic [WIDE_W-1:0] rawSum;
  logic              overflow;

  assign carryChain[0] = carryIn;

  for (genvar i = 0; i < WIDE_W; i++) begin : g_bit
    assign bMod[i]          = opB[i] ^ invertB;
    assign rawSum[i]        = opA[i] ^ bMod[i] ^ carryChain[i];
    assign carryChain[i+1]  = (opA[i] & bMod[i]) | (carryChain[i] & (opA[i] ^ bMod[i]));
  end

  // overflow: operands share a sign the result does not
  assign overflow = (opA[WIDE_W-1] == bMod[WIDE_W-1]) &&
                    (rawSum[WIDE_W-1] != opA[WIDE_W-1]);

  always_comb begin
    if (!overflow)            satSum = rawSum;
    else if (opA[WIDE_W-1])   satSum = NEG_LIMIT;
    else                      satSum = POS_LIMIT;
  end

endmodule

// File: rtl/llr_lane_datapath.sv
module llr_lane_datapath
  import llr_lane_pkg::*;
#(
  parameter int WIDE_W   = 6,
  parameter int NARROW_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  laneStrobes_t        strobes,
  input  logic [WIDE_W-1:0]   gammaOld,
  input  logic [NARROW_W-1:0] betaOld,
  input  logic [NARROW_W-1:0] betaNew,
  output logic [WIDE_W-1:0]   alphaWide,
  output logic [NARROW_W-1:0] alphaNarrow,
  output logic [WIDE_W-1:0]   gammaNew
);

  localparam int EXT_W = WIDE_W - NARROW_W;
  localparam logic signed [WIDE_W-1:0] N_MAX =
    {{(EXT_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] N_MIN =
    {{(EXT_W+1){1'b1}}, {(NARROW_W-1){1'b0}}};

  logic [WIDE_W-1:0]   alphaQ;
  logic [NARROW_W-1:0] alphaNarrowQ;
  logic [WIDE_W-1:0]   gammaQ;

  logic [WIDE_W-1:0]   opA;
  logic [NARROW_W-1:0] betaPick;
  logic [NARROW_W-1:0] betaGated;
  logic [WIDE_W-1:0]   opB;
  logic [WIDE_W-1:0]   sumSat;
  logic [NARROW_W-1:0] sumNarrow;

  // input multiplexers
  assign opA       = strobes.pickStored ? alphaQ : gammaOld;
  assign betaPick  = strobes.pickStored ? betaNew : betaOld;
  assign betaGated = strobes.betaPass ? betaPick : '0;
  assign opB       = {{EXT_W{betaGated[NARROW_W-1]}}, betaGated};

  llr_lane_adder #(.WIDE_W(WIDE_W)) u_add (
    .opA     (opA),
    .opB     (opB),
    .invertB (strobes.invertB),
    .carryIn (strobes.carryIn),
    .satSum  (sumSat)
  );

  // narrowing saturator toward the check-node unit
  always_comb begin
    if ($signed(sumSat) > N_MAX)      sumNarrow = N_MAX[NARROW_W-1:0];
    else if ($signed(sumSat) < N_MIN) sumNarrow = N_MIN[NARROW_W-1:0];
    else                              sumNarrow = sumSat[NARROW_W-1:0];
  end

  // output steering by mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alphaQ       <= '0;
      alphaNarrowQ <= '0;
    end else if (strobes.captureAlpha) begin
      alphaQ       <= sumSat;
      alphaNarrowQ <= sumNarrow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     gammaQ <= '0;
    else if (strobes.captureGamma) gammaQ <= sumSat;
  end

  assign alphaWide   = alphaQ;
  assign alphaNarrow = alphaNarrowQ;
  assign gammaNew    = gammaQ;

endmodule

// File: rtl/llr_lane.sv
module llr_lane
  import llr_lane_pkg::*;
#(
  parameter int WIDE_W   = 6,
  parameter int NARROW_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeSel,
  input  logic                laneOn,
  input  logic [WIDE_W-1:0]   gammaOld,
  input  logic [NARROW_W-1:0] betaOld,
  input  logic [NARROW_W-1:0] betaNew,
  output logic [WIDE_W-1:0]   alphaWide,
  output logic [NARROW_W-1:0] alphaNarrow,
  output logic [WIDE_W-1:0]   gammaNew
);

  laneStrobes_t strobes;

  llr_lane_ctrl u_ctrl (
    .modeSel (modeSel),
    .laneOn  (laneOn),
    .strobes (strobes)
  );

  llr_lane_datapath #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .gammaOld    (gammaOld),
    .betaOld     (betaOld),
    .betaNew     (betaNew),
    .alphaWide   (alphaWide),
    .alphaNarrow (alphaNarrow),
    .gammaNew    (gammaNew)
  );

endmodule

// File: rtl/llr_lane_chk.sv
module llr_lane_chk #(
  parameter int WIDE_W   = 6,
  parameter int NARROW_W = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                modeSel,
  input logic                laneOn,
  input logic [WIDE_W-1:0]   gammaOld,
  input logic [NARROW_W-1:0] betaNew,
  input logic [WIDE_W-1:0]   alphaWide,
  input logic [NARROW_W-1:0] alphaNarrow,
  input logic [WIDE_W-1:0]   gammaNew
);

  localparam int NMAX = (1 << (NARROW_W-1)) - 1;
  localparam int NMIN = -(1 << (NARROW_W-1));

  // R6: add cycle keeps the alpha registers
  assert_alpha_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    modeSel |=> (alphaWide == $past(alphaWide)) && (alphaNarrow == $past(alphaNarrow)));

  // R6: subtract cycle keeps the a-posteriori register
  assert_gamma_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !modeSel |=> gammaNew == $past(gammaNew));

  // R4: narrow output is the clamp of the wide one
  assert_narrow_clamp_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((int'($signed(alphaWide)) >= NMAX) ? (int'($signed(alphaNarrow)) == NMAX) :
     (int'($signed(alphaWide)) <= NMIN) ? (int'($signed(alphaNarrow)) == NMIN) :
     (alphaNarrow == alphaWide[NARROW_W-1:0])));

  // R7: disabled lane passes gammaOld into alpha
  assert_off_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!laneOn && !modeSel) |=> alphaWide == $past(gammaOld));

  // R5: zero check message leaves the held alpha as the new a-posteriori value
  assert_zero_add_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel && betaNew == '0) |=> gammaNew == $past(alphaWide));

endmodule

bind llr_lane llr_lane_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .modeSel     (modeSel),
  .laneOn      (laneOn),
  .gammaOld    (gammaOld),
  .betaNew     (betaNew),
  .alphaWide   (alphaWide),
  .alphaNarrow (alphaNarrow),
  .gammaNew    (gammaNew)
);

// File: tb/sim_llr_lane.sv
`timescale 1ns/1ps
module sim_llr_lane;

  localparam int WIDE_W   = 6;
  localparam int NARROW_W = 4;
  localparam int WMAX = (1 << (WIDE_W-1)) - 1;
  localparam int WMIN = -(1 << (WIDE_W-1));
  localparam int NMAX = (1 << (NARROW_W-1)) - 1;
  localparam int NMIN = -(1 << (NARROW_W-1));

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b0;
  logic laneOn = 1'b1;
  logic [WIDE_W-1:0]   gammaOld = '0;
  logic [NARROW_W-1:0] betaOld = '0;
  logic [NARROW_W-1:0] betaNew = '0;
  logic [WIDE_W-1:0]   alphaWide;
  logic [NARROW_W-1:0] alphaNarrow;
  logic [WIDE_W-1:0]   gammaNew;

  int checks = 0;
  int errors = 0;
  int expAlpha = 0;
  int expGamma = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  llr_lane #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .laneOn(laneOn),
    .gammaOld(gammaOld), .betaOld(betaOld), .betaNew(betaNew),
    .alphaWide(alphaWide), .alphaNarrow(alphaNarrow), .gammaNew(gammaNew)
  );

  function automatic int clampW(int v);
    return (v > WMAX) ? WMAX : (v < WMIN) ? WMIN : v;
  endfunction

  function automatic int clampN(int v);
    return (v > NMAX) ? NMAX : (v < NMIN) ? NMIN : v;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // one subtract cycle; R2/R3/R4/R7 results, R6 gamma unchanged
  task automatic vnStep(int g, int b, bit on, string req);
    @(negedge clk);
    modeSel  = 1'b0;
    laneOn   = on;
    gammaOld = WIDE_W'(g);
    betaOld  = NARROW_W'(b);
    betaNew  = NARROW_W'($urandom_range(0, 15));
    expAlpha = clampW(g - (on ? b : 0));
    @(posedge clk); #1;
    check(req, int'($signed(alphaWide)), expAlpha);
    check({req, "/R4"}, int'($signed(alphaNarrow)), clampN(expAlpha));
    check("R6 gamma kept", int'($signed(gammaNew)), expGamma);
  endtask

  // one add cycle; R5/R3/R7 result, R6 alpha unchanged
  task automatic apStep(int b, bit on, string req);
    @(negedge clk);
    modeSel  = 1'b1;
    laneOn   = on;
    betaNew  = NARROW_W'(b);
    betaOld  = NARROW_W'($urandom_range(0, 15));
    gammaOld = WIDE_W'($urandom_range(0, 63));
    expGamma = clampW(expAlpha + (on ? b : 0));
    @(posedge clk); #1;
    check(req, int'($signed(gammaNew)), expGamma);
    check("R6 alpha kept", int'($signed(alphaWide)), expAlpha);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R1 alphaWide", int'(alphaWide), 0);
    check("R1 alphaNarrow", int'(alphaNarrow), 0);
    check("R1 gammaNew", int'(gammaNew), 0);
    @(negedge clk);
    rstN = 1'b1;

    // directed cases
    vnStep(10, 3, 1'b1, "R2 plain subtract");
    apStep(-5, 1'b1, "R5 plain add");
    vnStep(31, -8, 1'b1, "R3 positive clamp subtract");
    apStep(7, 1'b1, "R3 positive clamp add");
    vnStep(-32, 7, 1'b1, "R3 negative clamp subtract");
    apStep(-8, 1'b1, "R3 negative clamp add");
    vnStep(20, 0, 1'b1, "R4 narrow high clamp");
    vnStep(-20, 0, 1'b1, "R4 narrow low clamp");
    vnStep(-8, 0, 1'b1, "R4 narrow edge");
    vnStep(17, 6, 1'b0, "R7 lane off subtract");
    apStep(-7, 1'b0, "R7 lane off add");
    apStep(0, 1'b1, "R5 zero add");

    // random layer steps
    for (int i = 0; i < 400; i++) begin
      int g, bo, bn;
      bit on;
      g  = int'($signed(WIDE_W'($urandom_range(0, 63))));
      bo = int'($signed(NARROW_W'($urandom_range(0, 15))));
      bn = int'($signed(NARROW_W'($urandom_range(0, 15))));
      on = ($urandom_range(0, 7) != 0);
      vnStep(g, bo, on, on ? "R2 random subtract" : "R7 random off");
      apStep(bn, on, on ? "R5 random add" : "R7 random off add");
    end

    // reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 alphaWide again", int'(alphaWide), 0);
    check("R1 gammaNew again", int'(gammaNew), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule